// File: doc/BRIEF.md
# Hardware Thread Switch Selector

This block decides which of several hardware thread contexts supplies the fetch stage of a single-issue pipeline on the next cycle. It has two scheduling modes. In interleaved mode it hands the fetch slot to a different ready thread on every cycle. A stall from one thread then costs nothing, because the other threads fill the slot. In switch-on-stall mode it keeps issuing from one thread and moves to another only when that thread reports a long-latency stall. When it moves, it pulses a pipeline flush for one cycle.

The per-thread program counters live outside the block. They are indexed by the selected thread ID. A valid flag tells the fetch stage whether the ID may be used in that cycle. The mode request is sampled only at a switch point. In interleaved mode every cycle is a switch point. In switch-on-stall mode only a long stall is one. A mode change therefore never lands in the middle of a thread's run.

Top module: `hw_thread_picker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sel_tid` is 0, `sel_valid` is 0 and `flush_pulse` is 0. Interleaved mode is the active mode.
- R2: In interleaved mode, each clock edge registers as the new `sel_tid` the first thread with a high `thr_ready` bit. The search starts at the current ID plus one and wraps at NUM_THR, so the current thread is examined last. `sel_valid` is 1 in that case.
- R3: In interleaved mode, a high `stall_vld` removes the current thread from that pick, whatever the value of `stall_long`. The other threads are searched in the same order. No flush is produced.
- R4: In interleaved mode, if no thread qualifies, `sel_valid` goes to 0 and `sel_tid` keeps its value.
- R5: In switch-on-stall mode, when there is no stall, or the stall is short (`stall_vld`=1, `stall_long`=0), `sel_tid` is kept. `sel_valid` becomes the `thr_ready` bit of that thread ANDed with NOT `stall_vld`.
- R6: In switch-on-stall mode, a long stall (`stall_vld`=1, `stall_long`=1) moves `sel_tid` to the first ready thread other than the current one, in the R2 search order. `sel_valid` is then 1, and `flush_pulse` is 1 in that same registered cycle only.
- R7: In switch-on-stall mode, if a long stall occurs and no other thread is ready, `sel_tid` is kept and `sel_valid` is 0. No flush occurs.
- R8: `mode_coarse` (1 = switch-on-stall) becomes the active mode for the next cycle only at a switch point. A switch point is any interleaved-mode cycle or a long-stall cycle in switch-on-stall mode. At any other time the input is ignored.
- R9: `flush_pulse` is never raised in a cycle that follows an interleaved-mode cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | NUM_THR | Per-thread ready flags |
| stall_vld | input | 1 | Current thread reports a stall |
| stall_long | input | 1 | Stall class: 1 = long latency, 0 = short |
| mode_coarse | input | 1 | Requested mode: 1 = switch-on-stall, 0 = interleaved |
| sel_tid | output | $clog2(NUM_THR) | Selected thread ID |
| sel_valid | output | 1 | Selected thread may issue this cycle |
| flush_pulse | output | 1 | One-cycle pipeline flush on a stall-driven switch |

## Verification
The bench builds the block with five threads. With five threads the ID field is three bits wide and the wrap happens at a count that is not a power of two. This exposes a search that wraps at the field width instead of at the thread count. Five threads also leave enough room for a search to skip several non-ready threads in a row, and to see the stalled thread excluded while others remain. A cycle-level model in the bench predicts all three outputs on every cycle. This covers both modes and the transitions between them, with the mode request toggled both at switch points and away from them.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int MAXT = 8;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } pick_t;

  // Search threads after 'last' in ascending order, wrapping at n.
  function automatic pick_t rr_next(input logic [MAXT-1:0] mask,
                                    input logic [2:0] last, input int n);
    pick_t r;
    r.hit = 1'b0;
    r.idx = last;
    for (int off = 1; off <= MAXT; off++) begin
      if (off <= n && !r.hit) begin
        logic [2:0] c;
        c = 3'((int'(last) + off) % n);
        if (mask[c]) begin
          r.hit = 1'b1;
          r.idx = c;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/thr_rr_pick.sv
module thr_rr_pick #(
  parameter int NUM_THR = 4,
  localparam int TID_W = $clog2(NUM_THR)
) (
  input  logic [NUM_THR-1:0] cand,
  input  logic [TID_W-1:0]   last,
  output logic               hit,
  output logic [TID_W-1:0]   idx
);
  import thr_pkg::*;
  pick_t p;
  always_comb begin
    p   = rr_next(MAXT'(cand), 3'(last), NUM_THR);
    hit = p.hit;
    idx = p.idx[TID_W-1:0];
  end
endmodule

// File: rtl/thr_mode_reg.sv
module thr_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic switch_pt,
  input  logic mode_req,
  output logic act_coarse
);
  always_ff @(posedge clk) begin
    if (!rst_n)         act_coarse <= 1'b0;
    else if (switch_pt) act_coarse <= mode_req;
  end
endmodule

// File: rtl/hw_thread_picker.sv
module hw_thread_picker #(
  parameter int NUM_THR = 4,
  localparam int TID_W = $clog2(NUM_THR),
  localparam int PAD_W = 1 << TID_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_THR-1:0] thr_ready,
  input  logic               stall_vld,
  input  logic               stall_long,
  input  logic               mode_coarse,
  output logic [TID_W-1:0]   sel_tid,
  output logic               sel_valid,
  output logic               flush_pulse
);
  logic               act_coarse;
  logic               long_stall;
  logic               excl_cur;
  logic               switch_pt;
  logic               coarse_switch;
  logic [NUM_THR-1:0] cur_bit;
  logic [NUM_THR-1:0] cand;
  logic [PAD_W-1:0]   ready_pad;
  logic               pick_hit;
  logic [TID_W-1:0]   pick_idx;
  logic [TID_W-1:0]   tid_d;
  logic               valid_d;

  assign long_stall = stall_vld & stall_long;
  assign excl_cur   = act_coarse ? long_stall : stall_vld;
  assign switch_pt  = !act_coarse || long_stall;
  assign cur_bit    = {{(NUM_THR-1){1'b0}}, 1'b1} << sel_tid;
  assign cand       = thr_ready & ~(excl_cur ? cur_bit : '0);
  assign ready_pad  = PAD_W'(thr_ready);

  thr_rr_pick #(.NUM_THR(NUM_THR)) u_pick (
    .cand(cand), .last(sel_tid), .hit(pick_hit), .idx(pick_idx)
  );

  thr_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .switch_pt(switch_pt),
    .mode_req(mode_coarse), .act_coarse(act_coarse)
  );

  assign coarse_switch = act_coarse && long_stall && pick_hit;

  always_comb begin
    tid_d   = sel_tid;
    valid_d = 1'b0;
    if (!act_coarse || long_stall) begin
      if (pick_hit) begin
        tid_d   = pick_idx;
        valid_d = 1'b1;
      end
    end else begin
      valid_d = ready_pad[sel_tid] && !stall_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_tid     <= '0;
      sel_valid   <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      sel_tid     <= tid_d;
      sel_valid   <= valid_d;
      flush_pulse <= coarse_switch;
    end
  end
endmodule

// File: rtl/thr_picker_chk.sv
module thr_picker_chk #(
  parameter int NUM_THR = 4,
  localparam int TID_W = $clog2(NUM_THR),
  localparam int PAD_W = 1 << TID_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_THR-1:0] thr_ready,
  input logic               stall_vld,
  input logic               stall_long,
  input logic [TID_W-1:0]   sel_tid,
  input logic               sel_valid,
  input logic               flush_pulse,
  input logic               act_coarse,
  input logic               coarse_switch
);
  logic [PAD_W-1:0] prev_ready;
  always_ff @(posedge clk) prev_ready <= PAD_W'(thr_ready);

  // R2 / R5 / R6: an issued thread was ready in the deciding cycle
  p_valid_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> prev_ready[sel_tid]);

  // R6: a flush is preceded by a stall-driven switch and lands on a new ID
  p_flush_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> ($past(coarse_switch) && sel_tid != $past(sel_tid)));

  // R9: no flush after an interleaved cycle
  p_fine_noflush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !act_coarse |=> !flush_pulse);

  // R5: thread held in switch-on-stall mode without a long stall
  p_coarse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_coarse && !(stall_vld && stall_long)) |=> $stable(sel_tid));

  // R4: nothing ready in interleaved mode
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_coarse && thr_ready == '0) |=> (!sel_valid && $stable(sel_tid)));

  // R8: mode kept away from switch points
  p_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (act_coarse && !(stall_vld && stall_long)) |=> act_coarse);
endmodule

bind hw_thread_picker thr_picker_chk #(.NUM_THR(NUM_THR)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .stall_vld(stall_vld),
  .stall_long(stall_long), .sel_tid(sel_tid), .sel_valid(sel_valid),
  .flush_pulse(flush_pulse), .act_coarse(act_coarse),
  .coarse_switch(coarse_switch)
);

// File: tb/tb_hw_thread_picker.sv
module tb_hw_thread_picker;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 5;
  localparam int TW = $clog2(NT);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] thr_ready = '0;
  logic          stall_vld = 1'b0;
  logic          stall_long = 1'b0;
  logic          mode_coarse = 1'b0;
  logic [TW-1:0] sel_tid;
  logic          sel_valid;
  logic          flush_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int  m_tid = 0;
  bit  m_coarse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_thread_picker #(.NUM_THR(NT)) dut (
    .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .stall_vld(stall_vld),
    .stall_long(stall_long), .mode_coarse(mode_coarse), .sel_tid(sel_tid),
    .sel_valid(sel_valid), .flush_pulse(flush_pulse)
  );

  function automatic int next_ready(int cur, logic [NT-1:0] m);
    int k = 1;
    while (k <= NT) begin
      if (m[(cur + k) % NT]) return (cur + k) % NT;
      k++;
    end
    return -1;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive inputs, predict, clock, compare all outputs.
  task automatic step(string tag, logic [NT-1:0] rdy, bit sv, bit sl, bit mc);
    logic [NT-1:0] m;
    int n;
    int e_tid;
    bit e_val;
    bit e_fl;
    bit ls;
    @(negedge clk);
    thr_ready = rdy; stall_vld = sv; stall_long = sl; mode_coarse = mc;
    ls = sv && sl;
    m = rdy;
    if (m_coarse ? ls : sv) m[m_tid] = 1'b0;
    e_tid = m_tid; e_val = 1'b0; e_fl = 1'b0;
    if (!m_coarse || ls) begin
      n = next_ready(m_tid, m);
      if (n >= 0) begin
        e_tid = n; e_val = 1'b1; e_fl = m_coarse;
      end
    end else begin
      e_val = rdy[m_tid] && !sv;
    end
    if (!m_coarse || ls) m_coarse = mc;
    m_tid = e_tid;
    @(posedge clk); #1;
    cmp(tag, "sel_tid", int'(sel_tid), e_tid);
    cmp(tag, "sel_valid", int'(sel_valid), int'(e_val));
    cmp(tag, "flush_pulse", int'(flush_pulse), int'(e_fl));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    cmp("R1", "sel_tid", int'(sel_tid), 0);
    cmp("R1", "sel_valid", int'(sel_valid), 0);
    cmp("R1", "flush_pulse", int'(flush_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    m_tid = 0; m_coarse = 1'b0;
  endtask

  task automatic t_fine_rotate;
    for (int i = 0; i < 7; i++) step("R2", 5'b11111, 0, 0, 0);
    step("R2", 5'b10010, 0, 0, 0);
    step("R2", 5'b10010, 0, 0, 0);
    step("R2", 5'b00100, 0, 0, 0);
    step("R2", 5'b00100, 0, 0, 0);
  endtask

  task automatic t_fine_stall;
    step("R3", 5'b01101, 1, 0, 0);
    step("R3", 5'b01101, 1, 1, 0);
    step("R3", 5'b01001, 1, 0, 0);
  endtask

  task automatic t_idle;
    step("R4", 5'b00000, 0, 0, 0);
    step("R4", 5'b00000, 0, 0, 0);
    step("R4", 5'b00001, 1, 0, 0);
    step("R4", 5'b01000, 0, 0, 0);
  endtask

  task automatic t_coarse;
    step("R8", 5'b11111, 0, 0, 1);
    step("R5", 5'b11111, 0, 0, 1);
    step("R5", 5'b11111, 1, 0, 1);
    step("R5", 5'b11111, 0, 0, 0);
    step("R8", 5'b11111, 0, 0, 0);
    step("R5", 5'b00000, 0, 0, 1);
    step("R6", 5'b10101, 1, 1, 1);
    step("R6", 5'b10101, 0, 0, 1);
    step("R6", 5'b11111, 1, 1, 1);
    step("R6", 5'b11111, 1, 1, 1);
    step("R7", 5'b00000, 1, 1, 1);
  endtask

  task automatic t_back_to_fine;
    int t;
    t = m_tid;
    step("R7", 5'b11111 & (5'b00001 << t), 1, 1, 0);
    step("R8", 5'b11111, 0, 0, 1);
    step("R9", 5'b11111, 1, 1, 0);
    step("R9", 5'b11111, 1, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fine_rotate();
    t_fine_stall();
    t_idle();
    t_coarse();
    t_back_to_fine();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule